// File: doc/BRIEF.md
# Sequential Flag-Offset Register Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Each offset is 18 bits wide and is stored as two 9-bit halves, which gives four small registers in total. Software or a host loads them over the shared 9-bit data input. While the active-low load strobe is held, each qualified write-clock edge stores one byte into the register selected by a wrapping write pointer. The pointer then moves on to the next register.

The write pointer keeps its position when the load strobe is released. A later load session therefore carries on from the register after the last one written. While the strobe is held, the same four registers can also be read back on the read clock. A separate read pointer steps through them in the same order. The assembled empty and full offsets are driven continuously to the flag generator. If a write and a read are requested together, the write takes priority.

Top module: `fol_loader`

## Requirements
- R1: After reset the registers hold these values: slot 0 (empty LSB) = 007h, slot 1 (empty MSB) = 000h, slot 2 (full LSB) = 007h, slot 3 (full MSB) = 000h. The read output is 000h, and both pointers select slot 0.
- R2: On a rising write-clock edge with `ld_n` = 0 and `wen_n` = 0, `din` is stored into the slot that the write pointer selects, and the write pointer moves to the next slot.
- R3: Slots are visited in the order 0, 1, 2, 3 and then wrap back to 0. Slot 0 is `empty_ofs[8:0]`, slot 1 is `empty_ofs[17:9]`, slot 2 is `full_ofs[8:0]` and slot 3 is `full_ofs[17:9]`.
- R4: A write-clock edge with `ld_n` = 1 or `wen_n` = 1 leaves every register and the write pointer unchanged.
- R5: The write pointer keeps its position while `ld_n` is high. The first write of the next session lands in the slot after the last one written.
- R6: On a rising read-clock edge with `ld_n`, `ren1_n` and `ren2_n` all 0 and `wen_n` = 1, `dout` takes the slot that the read pointer selects. The read pointer then moves on, following the R3 order with wrap-around.
- R7: If either read enable is high on a read-clock edge, `dout` and the read pointer hold their values.
- R8: If `wen_n` = 0 while a read is requested, no read happens: `dout` and the read pointer hold their values, and the write still proceeds.
- R9: The read pointer advances only on reads and the write pointer only on writes. Neither pointer moves the other.
- R10: `empty_ofs` and `full_ofs` always show the current register contents, arranged as described in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe; selects the offset registers |
| wen_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | First active-low read enable |
| ren2_n | input | 1 | Second active-low read enable |
| din | input | 9 | Byte written into the selected offset register |
| dout | output | 9 | Byte read back from the selected offset register |
| empty_ofs | output | 18 | Assembled almost-empty offset |
| full_ofs | output | 18 | Assembled almost-full offset |

## Verification
The assertions assume that every control input changes away from the edges of both clocks. They also assume that the read-back samples the register bank, which belongs to the write domain, only while no write lands in the same window. The bench meets these conditions by changing write-side inputs only on falling write-clock edges and read-side inputs only on falling read-clock edges. The two clock periods are chosen so that those instants never meet an opposite rising edge. The only case where reads and writes overlap is the deliberate collision scenario, in which the write-priority rule blocks the read.

// File: rtl/fol_pkg.sv
package fol_pkg;
  localparam int SLOT_CNT = 4;
  localparam int SLOT_W   = $clog2(SLOT_CNT);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOT_CNT - 1)) ? '0 : s + 1'b1;
  endfunction

  function automatic bit slot_is_low_half(input int idx);
    return (idx % 2) == 0;
  endfunction
endpackage

// File: rtl/fol_seq_ptr.sv
module fol_seq_ptr
  import fol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [SLOT_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= SLOT_EMPTY_LO;
    else if (step) ptr <= slot_after(ptr);
  end

  // R3: each step lands on the next slot, wrapping after the last one
  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr == slot_after($past(ptr)));

  // R5: without a step the position is kept
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
endmodule

// File: rtl/fol_bank.sv
module fol_bank
  import fol_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int LO_INIT = 7,
  parameter int HI_INIT = 0
) (
  input  logic                             wclk,
  input  logic                             rst_n,
  input  logic                             wr_fire,
  input  logic [SLOT_W-1:0]                wr_slot,
  input  logic [DATA_W-1:0]                din,
  output logic [SLOT_CNT-1:0][DATA_W-1:0]  regs
);
  for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
    localparam logic [DATA_W-1:0] INIT_V =
      slot_is_low_half(i) ? DATA_W'(LO_INIT) : DATA_W'(HI_INIT);
    logic hit;
    assign hit = wr_fire && (wr_slot == SLOT_W'(i));
    always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) regs[i] <= INIT_V;
      else if (hit) regs[i] <= din;
    end
  end

  // R2: the addressed slot captures the input byte
  assert_bank_write_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> regs[$past(wr_slot)] == $past(din));

  // R4: no qualified write, no change anywhere in the bank
  assert_bank_hold_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_fire |=> $stable(regs));
endmodule

// File: rtl/fol_readout.sv
module fol_readout
  import fol_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                            rclk,
  input  logic                            rst_n,
  input  logic                            rd_fire,
  input  logic [SLOT_W-1:0]               rd_slot,
  input  logic [SLOT_CNT-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]               dout
);
  logic [DATA_W-1:0] sel_data;
  assign sel_data = regs[rd_slot];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else if (rd_fire) dout <= sel_data;
  end

  // R6: a read presents the selected slot
  assert_read_data_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> dout == $past(regs[rd_slot]));

  // R7: without a read the output is held
  assert_read_hold_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(dout));
endmodule

// File: rtl/fol_loader.sv
module fol_loader
  import fol_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int LO_INIT = 7,
  parameter int HI_INIT = 0
) (
  input  logic                wclk,
  input  logic                rclk,
  input  logic                rst_n,
  input  logic                ld_n,
  input  logic                wen_n,
  input  logic                ren1_n,
  input  logic                ren2_n,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic [2*DATA_W-1:0] empty_ofs,
  output logic [2*DATA_W-1:0] full_ofs
);
  logic                            wr_req;
  logic                            rd_req;
  logic                            wr_fire;
  logic                            rd_fire;
  logic [SLOT_W-1:0]               wr_ptr;
  logic [SLOT_W-1:0]               rd_ptr;
  logic [SLOT_CNT-1:0][DATA_W-1:0] regs;

  assign wr_req  = !ld_n && !wen_n;
  assign rd_req  = !ld_n && !ren1_n && !ren2_n;
  assign wr_fire = wr_req;
  assign rd_fire = rd_req && !wr_req;

  fol_seq_ptr u_wr_ptr (
    .clk   (wclk),
    .rst_n (rst_n),
    .step  (wr_fire),
    .ptr   (wr_ptr)
  );

  fol_seq_ptr u_rd_ptr (
    .clk   (rclk),
    .rst_n (rst_n),
    .step  (rd_fire),
    .ptr   (rd_ptr)
  );

  fol_bank #(
    .DATA_W  (DATA_W),
    .LO_INIT (LO_INIT),
    .HI_INIT (HI_INIT)
  ) u_bank (
    .wclk    (wclk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_slot (wr_ptr),
    .din     (din),
    .regs    (regs)
  );

  fol_readout #(
    .DATA_W (DATA_W)
  ) u_readout (
    .rclk    (rclk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .rd_slot (rd_ptr),
    .regs    (regs),
    .dout    (dout)
  );

  assign empty_ofs = {regs[SLOT_EMPTY_HI], regs[SLOT_EMPTY_LO]};
  assign full_ofs  = {regs[SLOT_FULL_HI],  regs[SLOT_FULL_LO]};

  // R8: a read request overlapped by a write leaves read state untouched
  assert_collision_hold_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && !wen_n) |=> ($stable(rd_ptr) && $stable(dout)));

  // R9: the write pointer does not move on read-clock activity alone
  assert_wr_ptr_isolated_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_req) |=> $stable(wr_ptr));

  // R10: the low half of the empty offset follows the first slot
  assert_empty_lo_map_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wr_ptr == SLOT_EMPTY_LO) |=> empty_ofs[DATA_W-1:0] == $past(din));
endmodule

// File: tb/fol_loader_bench.sv
module fol_loader_bench;
  localparam int WCLK_HALF = 5;
  localparam int RCLK_HALF = 7;
  localparam int DW        = 9;
  localparam int WATCHDOG  = 200000;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_n = 1'b1;
  logic          wen_n = 1'b1;
  logic          ren1_n = 1'b1;
  logic          ren2_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [2*DW-1:0] empty_ofs;
  logic [2*DW-1:0] full_ofs;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] model [4];
  int wp = 0;
  int rp = 0;
  logic [DW-1:0] last_out = '0;

  always #WCLK_HALF wclk = ~wclk;
  always #RCLK_HALF rclk = ~rclk;

  fol_loader u_fol_loader (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_offsets(input string req);
    check(req, 32'(empty_ofs), 32'({model[1], model[0]}));
    check(req, 32'(full_ofs),  32'({model[3], model[2]}));
  endtask

  task automatic set_load(input logic v);
    @(negedge wclk) ld_n = v;
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    @(negedge wclk);
    din = v; wen_n = 1'b0;
    @(negedge wclk);
    wen_n = 1'b1;
    model[wp] = v;
    wp = (wp + 1) % 4;
  endtask

  task automatic do_read(input string req);
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    last_out = model[rp];
    rp = (rp + 1) % 4;
    check(req, 32'(dout), 32'(last_out));
  endtask

  task automatic t_reset;
    check("R1 empty", 32'(empty_ofs), 32'h007);
    check("R1 full", 32'(full_ofs), 32'h007);
    check("R1 dout", 32'(dout), 32'h0);
    set_load(1'b0);
    for (int i = 0; i < 4; i++) do_read("R1 R6 reset readback");
  endtask

  task automatic t_sequence;
    do_write(9'h1A1); do_write(9'h0B2); do_write(9'h1C3); do_write(9'h0D4);
    check_offsets("R2 R3 R10 full pass");
    do_write(9'h155);
    check("R3 wrap to slot0", 32'(empty_ofs[DW-1:0]), 32'h155);
    check_offsets("R3 wrap others kept");
  endtask

  task automatic t_gated;
    set_load(1'b1);
    @(negedge wclk) din = 9'h1FF; wen_n = 1'b0;
    repeat (3) @(negedge wclk);
    wen_n = 1'b1;
    check_offsets("R4 strobe high");
    set_load(1'b0);
    repeat (3) @(negedge wclk);
    check_offsets("R4 enable high");
    do_write(9'h0AA);
    check_offsets("R4 pointer kept");
  endtask

  task automatic t_partial;
    do_write(9'h011);
    set_load(1'b1);
    repeat (4) @(negedge wclk);
    set_load(1'b0);
    do_write(9'h022);
    check("R5 resumed slot", 32'(full_ofs), 32'({9'h022, 9'h011}));
    check_offsets("R5 partial session");
  endtask

  task automatic t_read_enables;
    @(negedge rclk) ren1_n = 1'b0;
    repeat (2) @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b0;
    repeat (2) @(negedge rclk);
    ren2_n = 1'b1;
    check("R7 single enable holds dout", 32'(dout), 32'(last_out));
    do_read("R7 read pointer held");
  endtask

  task automatic t_collision;
    @(negedge wclk);
    din = 9'h077; wen_n = 1'b0;
    #2 ren1_n = 1'b0; ren2_n = 1'b0;
    #26 ren1_n = 1'b1; ren2_n = 1'b1;
    @(negedge wclk) wen_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      model[wp] = 9'h077;
      wp = (wp + 1) % 4;
    end
    check("R8 dout held", 32'(dout), 32'(last_out));
    check_offsets("R8 write proceeded");
    do_read("R8 read pointer held");
  endtask

  task automatic t_independent;
    check("R9 pointers differ", 32'(wp != rp), 32'd1);
    do_read("R9 read sequence");
    do_read("R9 read sequence wrap");
    do_write(9'h133);
    check_offsets("R9 write after reads");
    do_read("R9 read after write");
  endtask

  initial begin
    model[0] = 9'h007; model[1] = 9'h000; model[2] = 9'h007; model[3] = 9'h000;
    #32 rst_n = 1'b1;
    t_reset();
    t_sequence();
    t_gated();
    t_partial();
    t_read_enables();
    t_collision();
    t_independent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(WATCHDOG * 2 * WCLK_HALF);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule